// File: doc/BRIEF.md
# Stack machine instruction sequencer

This unit is the control core of a stack-oriented processor with separate code and data stores. It owns the code pointer, the instruction register and a two-bit run status. It fetches 32-bit instruction words from a code memory that answers one cycle after a request is accepted. It decodes the operation and carries out the control-flow operations itself: direct jump, indirect jump, conditional jump and halt. Every other legal operation is handed to the data-path unit over a dispatch channel. The conditional and indirect jumps obtain their operand by popping one 16-bit word from the data-path stack over a pop channel. Register values are read from the data path through a combinational select.

Each instruction runs to completion before the next fetch, so there is never more than one instruction in flight. Any new code-pointer value is checked against the code store size before it is committed. That includes the plain step to the next word. The fetch request, the pop and the dispatch are valid/ready channels. A valid is raised only by this unit. Once raised, the valid and its payload stay unchanged until the cycle in which ready is high, and the transfer happens at that clock edge. The code memory has no ready on its response: the word must be on `code_rsp_data` in the cycle after the request was accepted. The pop word is sampled in the cycle where `pop_valid` and `pop_ready` are both high.

Top module: `stk_seq_unit`

## Requirements
- R1: While and right after reset, the status is running (0), the code pointer is 0, and a fetch request for code address 0 is presented.
- R2: A fetch request is raised only while the status is running. Its valid and address hold until accepted. The fetched word is taken from `code_rsp_data` one cycle after acceptance and split as op = bits 31:28, r = 27:24, n = 23:16, d = 15:0, where d is two's complement.
- R3: Op 9 sets the status to invalid-instruction (2). The code pointer keeps that instruction's address, and no later fetch, pop or dispatch follows.
- R4: Op 15 (halt) sets the status to halted (1) and keeps the code pointer at the halt's address, with no pop or dispatch.
- R5: Op 12 (direct jump) sets the code pointer to Reg(r) + d and neither pops nor dispatches.
- R6: Op 13 (indirect jump) pops one word and sets the code pointer to that word, read as unsigned.
- R7: Op 14 (conditional jump) pops one word. If the word equals n zero-extended, the code pointer becomes Reg(r) + d; otherwise it becomes its old value plus 1.
- R8: A new code-pointer value that is negative or not below CODE_DEPTH sets the status to code-address error (3) and leaves the code pointer at the faulting instruction's address. This applies to a jump target and to stepping past the last word.
- R9: Ops 0 to 8, 10 and 11 are presented on the dispatch channel with the full instruction word, held until accepted. The code pointer then advances by 1.
- R10: The pop valid holds until accepted. Exactly one pop takes place for each op 13 or op 14, and none for any other op.
- R11: A halted or error status is final until reset: the status and code pointer no longer change and no channel raises valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_req_valid | output | 1 | Fetch request valid |
| code_req_ready | input | 1 | Code memory accepts the request |
| code_req_addr | output | ADDR_W | Code address to fetch |
| code_rsp_data | input | 32 | Instruction word, one cycle after acceptance |
| pop_valid | output | 1 | Request to pop one stack word |
| pop_ready | input | 1 | Data path supplies the popped word |
| pop_data | input | DATA_W | Popped stack word |
| reg_sel | output | 4 | Register index (r field) for the data-path read |
| reg_val | input | DATA_W | Contents of the selected register |
| disp_valid | output | 1 | Dispatch of a data-path instruction |
| disp_ready | input | 1 | Data path accepts the dispatch |
| disp_word | output | 32 | Instruction word being dispatched |
| code_ptr | output | ADDR_W | Current code pointer |
| run_status | output | 2 | 0 running, 1 halted, 2 invalid instruction, 3 code-address error |

## Verification
A directed program passes through every control-flow path in turn: a negative displacement on a direct jump, a conditional jump whose popped word matches n, one whose word does not match, an indirect jump, dispatched words, and a final halt. These tell apart the three ways of forming a target. Short programs then aim at the edges of the code range: a target of -1, a target equal to the code size, a jump to exactly the last word, and a plain step or a failed conditional off the last word. Together they separate the range check from target formation and confirm that the pointer is kept on a fault. Random programs with random register values, popped words and ready timing check every fetched address against an instruction-level model. Back-pressure on each channel then shows whether a held valid ever loses or repeats a transfer.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  typedef enum logic [1:0] {
    RUN_OK       = 2'd0,
    RUN_HALTED   = 2'd1,
    RUN_BAD_OP   = 2'd2,
    RUN_BAD_ADDR = 2'd3
  } run_state_e;

  typedef enum logic [2:0] {
    K_HANDOFF,
    K_JUMP,
    K_JUMPI,
    K_JUMPIF,
    K_HALT,
    K_ILLEGAL
  } op_kind_e;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  r;
    logic [7:0]  n;
    logic [15:0] d;
  } iword_t;

  localparam logic [3:0] OPC_HOLE   = 4'd9;
  localparam logic [3:0] OPC_JUMP   = 4'd12;
  localparam logic [3:0] OPC_JUMPI  = 4'd13;
  localparam logic [3:0] OPC_JUMPIF = 4'd14;
  localparam logic [3:0] OPC_HALT   = 4'd15;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_seq_pkg::*;
(
  input  logic [3:0] op,
  output op_kind_e   kind
);

  always_comb begin
    case (op)
      OPC_HOLE:   kind = K_ILLEGAL;
      OPC_JUMP:   kind = K_JUMP;
      OPC_JUMPI:  kind = K_JUMPI;
      OPC_JUMPIF: kind = K_JUMPIF;
      OPC_HALT:   kind = K_HALT;
      default:    kind = K_HANDOFF;
    endcase
  end

endmodule

// File: rtl/stk_tgt_sel.sv
module stk_tgt_sel
  import stk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TW     = DATA_W + 2
) (
  input  op_kind_e          kind,
  input  logic [ADDR_W-1:0] cp,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] pop_data,
  input  logic [7:0]        n,
  input  logic [15:0]       d,
  output logic [TW-1:0]     cand
);

  localparam int DPAD = TW - 16;
  localparam int RPAD = TW - DATA_W;
  localparam int CPAD = TW - ADDR_W;

  logic [TW-1:0] direct, step, popped;
  logic          match;

  // two's complement sum; the top bit marks a negative target
  assign direct = {{RPAD{1'b0}}, reg_val} + {{DPAD{d[15]}}, d};
  assign step   = {{CPAD{1'b0}}, cp} + {{(TW-1){1'b0}}, 1'b1};
  assign popped = {{RPAD{1'b0}}, pop_data};
  assign match  = (pop_data == {{(DATA_W-8){1'b0}}, n});

  always_comb begin
    case (kind)
      K_JUMP:   cand = direct;
      K_JUMPI:  cand = popped;
      K_JUMPIF: cand = match ? direct : step;
      default:  cand = step;
    endcase
  end

endmodule

// File: rtl/stk_addr_chk.sv
module stk_addr_chk #(
  parameter int CODE_DEPTH = 1024,
  parameter int TW         = 18
) (
  input  logic [TW-1:0] cand,
  output logic          ok
);

  localparam logic [TW-1:0] LIMIT = TW'(CODE_DEPTH);
  localparam bit            POW2  = (CODE_DEPTH & (CODE_DEPTH - 1)) == 0;

  generate
    if (POW2) begin : g_mask
      localparam logic [TW-1:0] HIGH = ~(LIMIT - {{(TW-1){1'b0}}, 1'b1});
      assign ok = (cand & HIGH) == '0;
    end else begin : g_cmp
      assign ok = !cand[TW-1] && (cand < LIMIT);
    end
  endgenerate

endmodule

// File: rtl/stk_seq_unit.sv
module stk_seq_unit
  import stk_seq_pkg::*;
#(
  parameter int CODE_DEPTH = 1024,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              code_req_valid,
  input  logic              code_req_ready,
  output logic [ADDR_W-1:0] code_req_addr,
  input  logic [31:0]       code_rsp_data,
  output logic              pop_valid,
  input  logic              pop_ready,
  input  logic [DATA_W-1:0] pop_data,
  output logic [3:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_val,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [31:0]       disp_word,
  output logic [ADDR_W-1:0] code_ptr,
  output logic [1:0]        run_status
);

  localparam int TW = DATA_W + 2;

  typedef enum logic [2:0] {PH_REQ, PH_WAIT, PH_DEC, PH_POP, PH_DISP, PH_STOP} phase_e;

  phase_e            ph;
  logic [ADDR_W-1:0] cp_q;
  iword_t            ir_q;
  run_state_e        st_q;
  op_kind_e          kind;
  logic [TW-1:0]     cand;
  logic              cand_ok;
  logic              commit;

  stk_decode u_dec (
    .op   (ir_q.op),
    .kind (kind)
  );

  stk_tgt_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TW(TW)) u_sel (
    .kind     (kind),
    .cp       (cp_q),
    .reg_val  (reg_val),
    .pop_data (pop_data),
    .n        (ir_q.n),
    .d        (ir_q.d),
    .cand     (cand)
  );

  stk_addr_chk #(.CODE_DEPTH(CODE_DEPTH), .TW(TW)) u_chk (
    .cand (cand),
    .ok   (cand_ok)
  );

  // the cycle in which the next code pointer is decided
  always_comb begin
    case (ph)
      PH_DEC:  commit = (kind == K_JUMP);
      PH_POP:  commit = pop_ready;
      PH_DISP: commit = disp_ready;
      default: commit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_REQ;
      cp_q <= '0;
      ir_q <= '0;
      st_q <= RUN_OK;
    end else begin
      case (ph)
        PH_REQ:  if (code_req_ready) ph <= PH_WAIT;
        PH_WAIT: begin
          ir_q <= code_rsp_data;
          ph   <= PH_DEC;
        end
        PH_DEC: begin
          case (kind)
            K_ILLEGAL: begin
              st_q <= RUN_BAD_OP;
              ph   <= PH_STOP;
            end
            K_HALT: begin
              st_q <= RUN_HALTED;
              ph   <= PH_STOP;
            end
            K_JUMPI, K_JUMPIF: ph <= PH_POP;
            K_HANDOFF:         ph <= PH_DISP;
            default: ;
          endcase
        end
        default: ;
      endcase
      if (commit) begin
        if (cand_ok) begin
          cp_q <= cand[ADDR_W-1:0];
          ph   <= PH_REQ;
        end else begin
          st_q <= RUN_BAD_ADDR;
          ph   <= PH_STOP;
        end
      end
    end
  end

  assign code_req_valid = (ph == PH_REQ);
  assign code_req_addr  = cp_q;
  assign pop_valid      = (ph == PH_POP);
  assign disp_valid     = (ph == PH_DISP);
  assign disp_word      = ir_q;
  assign reg_sel        = ir_q.r;
  assign code_ptr       = cp_q;
  assign run_status     = st_q;

  p_fetch_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code_req_valid |-> run_status == RUN_OK);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code_req_valid && !code_req_ready |=> code_req_valid && $stable(code_req_addr));

  p_req_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_req_valid |-> code_req_addr < ADDR_W'(CODE_DEPTH));

  p_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && !pop_ready |=> pop_valid);

  p_disp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_word));

  p_one_channel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({code_req_valid, pop_valid, disp_valid}));

  p_bad_op_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_status == RUN_BAD_OP && $past(run_status) == RUN_OK |-> $past(ir_q.op) == OPC_HOLE);

  p_addr_err_keeps_cp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_status == RUN_BAD_ADDR && $past(run_status) == RUN_OK |-> $stable(code_ptr));

  p_stop_final_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_status != RUN_OK |=> $stable(run_status) && $stable(code_ptr) &&
                             !code_req_valid && !pop_valid && !disp_valid);

endmodule

// File: tb/stk_seq_unit_test.sv
module stk_seq_unit_test;

  localparam int DEPTH = 64;
  localparam int AW    = 16;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          code_req_valid, code_req_ready;
  logic [AW-1:0] code_req_addr;
  logic [31:0]   code_rsp_data;
  logic          pop_valid, pop_ready;
  logic [DW-1:0] pop_data;
  logic [3:0]    reg_sel;
  logic [DW-1:0] reg_val;
  logic          disp_valid, disp_ready;
  logic [31:0]   disp_word;
  logic [AW-1:0] code_ptr;
  logic [1:0]    run_status;

  logic [31:0] mem  [DEPTH];
  logic [15:0] regs [16];
  logic [15:0] popv [64];

  always #2.5ns clk = ~clk;

  assign reg_val = regs[reg_sel];

  stk_seq_unit #(.CODE_DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk, .rst_n, .code_req_valid, .code_req_ready, .code_req_addr, .code_rsp_data,
    .pop_valid, .pop_ready, .pop_data, .reg_sel, .reg_val,
    .disp_valid, .disp_ready, .disp_word, .code_ptr, .run_status
  );

  int    n_chk = 0, n_bad = 0;
  int    m_cp, m_st, m_pops, m_disp, m_last, fetches, dut_pops, dut_disp, pidx;
  bit    pop_fired;
  string m_tag;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int op, int r, int n, int d);
    logic [3:0] o = op[3:0];
    logic [3:0] rr = r[3:0];
    logic [7:0] nn = n[7:0];
    logic [15:0] dd = d[15:0];
    return {o, rr, nn, dd};
  endfunction

  // instruction-level reference, stepped once per accepted fetch
  task automatic model_step(int a);
    logic [31:0] w = mem[a];
    int op = int'(w[31:28]);
    int r  = int'(w[27:24]);
    int n  = int'(w[23:16]);
    int dir = int'(regs[r]) + int'($signed(w[15:0]));
    int nxt = a + 1;
    int v;
    bit moves = 1'b1;
    m_last = a;
    case (op)
      9:  begin m_st = 2; m_tag = "R3"; moves = 1'b0; end
      15: begin m_st = 1; m_tag = "R4"; moves = 1'b0; end
      12: begin nxt = dir; m_tag = "R5"; end
      13: begin nxt = int'(popv[m_pops % 64]); m_pops++; m_tag = "R6"; end
      14: begin
        v = int'(popv[m_pops % 64]); m_pops++;
        nxt = (v == n) ? dir : a + 1;
        m_tag = "R7";
      end
      default: begin m_disp++; m_tag = "R9"; end
    endcase
    if (moves) begin
      if (nxt < 0 || nxt >= DEPTH) begin
        m_st = 3; m_tag = "R8";
      end else m_cp = nxt;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (pop_fired) begin pidx++; pop_fired = 1'b0; end
    pop_data       = popv[pidx % 64];
    code_req_ready = ($urandom % 4) != 0;
    pop_ready      = ($urandom % 3) != 0;
    disp_ready     = ($urandom % 3) != 0;
    if (code_req_valid && code_req_ready) begin
      chk(m_st == 0, "R2", "fetch issued while stopped", m_st, 0);
      chk(int'(code_req_addr) == m_cp, m_tag, "fetch address", int'(code_req_addr), m_cp);
      code_rsp_data = mem[code_req_addr[5:0]];
      if (m_st == 0) begin
        model_step(m_cp);
        fetches++;
      end
    end
    if (pop_valid && pop_ready) begin
      pop_fired = 1'b1;
      dut_pops++;
    end
    if (disp_valid && disp_ready) begin
      dut_disp++;
      chk(disp_word == mem[m_last], "R9", "dispatched word", int'(disp_word[31:28]), int'(mem[m_last][31:28]));
    end
  endtask

  task automatic run(int maxf);
    int guard = 0;
    rst_n = 1'b0; code_req_ready = 1'b0; pop_ready = 1'b0; disp_ready = 1'b0;
    pidx = 0; pop_fired = 1'b0; pop_data = popv[0]; code_rsp_data = '0;
    m_cp = 0; m_st = 0; m_pops = 0; m_disp = 0; m_last = 0; m_tag = "R1";
    fetches = 0; dut_pops = 0; dut_disp = 0;
    repeat (3) @(negedge clk);
    chk(run_status == 2'd0, "R1", "status in reset", int'(run_status), 0);
    chk(code_ptr == '0, "R1", "code pointer in reset", int'(code_ptr), 0);
    chk(code_req_valid && code_req_addr == '0, "R1", "first request", int'(code_req_valid), 1);
    rst_n = 1'b1;
    while (m_st == 0 && fetches < maxf && guard < 4000) begin
      cyc();
      guard++;
    end
    if (guard >= 4000) chk(1'b0, "R2", "run made no progress", guard, 0);
    if (m_st != 0) begin
      repeat (30) cyc();
      chk(int'(run_status) == m_st, m_tag, "final status", int'(run_status), m_st);
      chk(int'(code_ptr) == m_cp, m_tag, "final code pointer", int'(code_ptr), m_cp);
      chk(dut_pops == m_pops, "R10", "pop count", dut_pops, m_pops);
      chk(dut_disp == m_disp, "R9", "dispatch count", dut_disp, m_disp);
      chk(!code_req_valid && !pop_valid && !disp_valid, "R11", "channels idle after stop",
          int'({code_req_valid, pop_valid, disp_valid}), 0);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(9, 0, 0, 0);
    for (int i = 0; i < 16; i++) regs[i] = 16'(i * 3);
    for (int i = 0; i < 64; i++) popv[i] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; code_req_ready = 1'b0; pop_ready = 1'b0; disp_ready = 1'b0;
    pop_data = '0; code_rsp_data = '0;

    // R5 R6 R7 R9 R4: every control path, ending in halt at 41
    clear_prog();
    regs[1] = 16'd0; regs[2] = 16'd20;
    mem[0]  = mk(3, 0, 0, 5);
    mem[1]  = mk(12, 2, 0, -15);
    mem[5]  = mk(14, 1, 7, 10);
    mem[10] = mk(14, 1, 7, 30);
    mem[11] = mk(13, 0, 0, 0);
    mem[40] = mk(10, 0, 0, 2);
    mem[41] = mk(15, 0, 0, 0);
    popv[0] = 16'd7; popv[1] = 16'd3; popv[2] = 16'd40;
    run(100);

    // R3: hole opcode after one dispatch, pointer stays at 1
    clear_prog();
    mem[0] = mk(0, 0, 0, 0);
    run(100);

    // R8: direct target of -1
    clear_prog();
    regs[2] = 16'd20;
    mem[0] = mk(12, 2, 0, -21);
    run(100);

    // R8 R6: indirect target equal to the code size
    clear_prog();
    mem[0] = mk(13, 0, 0, 0);
    popv[0] = 16'd64;
    run(100);

    // R8 R9: step past the last word after a dispatch there
    clear_prog();
    mem[0] = mk(13, 0, 0, 0);
    mem[63] = mk(11, 0, 0, 1);
    popv[0] = 16'd63;
    run(100);

    // R5 R4: direct jump to exactly the last word, halt there
    clear_prog();
    regs[3] = 16'd60;
    mem[0] = mk(12, 3, 0, 3);
    mem[63] = mk(15, 0, 0, 0);
    run(100);

    // R7 R8: untaken conditional on the last word
    clear_prog();
    mem[0] = mk(13, 0, 0, 0);
    mem[63] = mk(14, 0, 5, 0);
    popv[0] = 16'd63; popv[1] = 16'd4;
    run(100);

    // random programs
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < DEPTH; i++) begin
        int op = int'($urandom % 16);
        if (op == 9 && ($urandom % 4) != 0) op = 12;
        mem[i] = mk(op, int'($urandom % 4), int'($urandom % 4), int'($urandom % 70) - 3);
      end
      for (int i = 0; i < 16; i++) regs[i] = 16'($urandom % 64);
      for (int i = 0; i < 64; i++)
        popv[i] = (($urandom % 2) == 0) ? 16'($urandom % 4) : 16'($urandom % 66);
      run(40);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule